// File: doc/BRIEF.md
# Exhaustive Hamming Error Evaluator

This block scores how far a candidate combinational function strays from a reference function over a complete input space. After a start pulse it sweeps a counter through all 2^NI input vectors and presents one vector per clock on its vector port. Both external functions answer each vector one clock later on two response ports. The block XORs the two responses bit by bit. It keeps a mismatch count for every output bit and a running total across all outputs.

At the end of the sweep it raises a one-cycle done pulse. It then gives a verdict on the total against a target mismatch total supplied on an input port. The average Hamming error is total / 2^NI, and the target is given on the same scale. A total within plus or minus 5 % of the target is accepted. Anything else is rejected and should not be ranked further. A zero total flags the two functions as equivalent. The counts stay on the ports until the next start, so the whole error profile can be read out.

Top module: `hamming_eval`

## Requirements
- R1: During reset and after it, busy, done, vec_valid, accept, reject and equiv are 0, and all counts read 0.
- R2: A start pulse clears all counts. In the next cycle vector 0 is on vec with vec_valid high, and vec then rises by exactly one each clock up to 2^NI-1. After that, vec_valid drops.
- R3: The responses on ref_resp and cand_resp are sampled in the cycle after the cycle in which their vector was on vec.
- R4: Per-output count i (bits i*CNT_W upward in per_cnt) equals the number of vectors for which bit i of ref_resp differs from bit i of cand_resp.
- R5: total equals the sum of all per-output counts, and it never decreases except when cleared by start.
- R6: done is high for exactly one cycle, two cycles after the last vector was on vec; busy is 0 in that cycle.
- R7: accept is high in the done cycle if and only if 19*tgt_total <= 20*total <= 21*tgt_total. The test uses integers only.
- R8: reject is high in the done cycle if and only if accept is not; both are 0 outside the done cycle.
- R9: equiv is high in the done cycle if and only if total is 0.
- R10: The counts and total hold their final values after done until the next start.
- R11: A start pulse during a sweep abandons it and begins a fresh sweep from vector 0 with cleared counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: clear counts and begin a sweep |
| tgt_total | input | ACC_W | Target mismatch total for the band test |
| vec | output | NI | Input vector applied to both functions |
| vec_valid | output | 1 | vec carries a vector of the sweep |
| ref_resp | input | NO | Reference response, one cycle after its vector |
| cand_resp | input | NO | Candidate response, one cycle after its vector |
| busy | output | 1 | Sweep or last response still pending |
| done | output | 1 | One-cycle pulse: counts final, verdict valid |
| per_cnt | output | NO*CNT_W | Per-output mismatch counts, output i at bits i*CNT_W |
| total | output | ACC_W | Sum of all mismatches |
| accept | output | 1 | Total within the band around the target |
| reject | output | 1 | Total outside the band |
| equiv | output | 1 | Functions agree on every vector |

## Verification
The assertions assume that start arrives as a pulse and that tgt_total stays stable between start and done. They also assume the response ports carry a valid answer in the cycle after each vector. The bench respects these assumptions by driving responses half a cycle after each clock edge, as a function of the vector captured at that edge. It changes the target and the candidate function only together with a start pulse. Restarts are issued only mid-sweep, so the discarded in-flight response never meets a valid vector slot.

// File: rtl/hamming_eval_pkg.sv
package hamming_eval_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/hev_seq.sv
module hev_seq
  import hamming_eval_pkg::*;
#(
  parameter int NI = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [NI-1:0] vec,
  output logic          vec_valid,
  output logic          rsp_vld,
  output logic          rsp_last
);
  localparam logic [NI-1:0] LAST_IDX = {NI{1'b1}};

  phase_e        ph_q, ph_d;
  logic [NI-1:0] idx_q, idx_d;
  logic          rv_q, rv_d;
  logic          rl_q, rl_d;
  logic          upd_en;

  always_comb begin
    ph_d  = ph_q;
    idx_d = idx_q;
    rv_d  = (ph_q == PH_RUN);
    rl_d  = (ph_q == PH_RUN) && (idx_q == LAST_IDX);
    if (start) begin
      ph_d  = PH_RUN;
      idx_d = '0;
      rv_d  = 1'b0;
      rl_d  = 1'b0;
    end else if (ph_q == PH_RUN) begin
      if (idx_q == LAST_IDX) ph_d = PH_IDLE;
      else                   idx_d = idx_q + 1'b1;
    end
  end

  assign upd_en = start || (ph_q == PH_RUN) || rv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
      rv_q  <= 1'b0;
      rl_q  <= 1'b0;
    end else if (upd_en) begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
      rv_q  <= rv_d;
      rl_q  <= rl_d;
    end
  end

  assign vec       = idx_q;
  assign vec_valid = (ph_q == PH_RUN);
  assign rsp_vld   = rv_q;
  assign rsp_last  = rl_q;
endmodule

// File: rtl/hev_acc.sv
module hev_acc #(
  parameter int NO    = 4,
  parameter int CNT_W = 9,
  parameter int ACC_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic [NO-1:0]       diff,
  output logic [NO*CNT_W-1:0] per_cnt,
  output logic [ACC_W-1:0]    total
);
  logic [ACC_W-1:0] pop;
  logic [ACC_W-1:0] tot_q, tot_d;
  logic             tot_en;

  always_comb begin
    pop = '0;
    for (int i = 0; i < NO; i++) pop = pop + ACC_W'(diff[i]);
  end

  for (genvar g = 0; g < NO; g++) begin : g_out
    logic [CNT_W-1:0] c_q, c_d;
    logic             c_en;
    assign c_en = clr || (en && diff[g]);
    assign c_d  = clr ? '0 : c_q + 1'b1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    c_q <= '0;
      else if (c_en) c_q <= c_d;
    end
    assign per_cnt[g*CNT_W +: CNT_W] = c_q;
  end

  assign tot_en = clr || en;
  assign tot_d  = clr ? '0 : tot_q + pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tot_q <= '0;
    else if (tot_en) tot_q <= tot_d;
  end

  assign total = tot_q;
endmodule

// File: rtl/hev_band.sv
module hev_band #(
  parameter int ACC_W = 11
) (
  input  logic [ACC_W-1:0] total,
  input  logic [ACC_W-1:0] target,
  output logic             in_band
);
  localparam int MUL_W = ACC_W + 5;

  logic [MUL_W-1:0] s, t, s20, t19, t21;

  always_comb begin
    s       = MUL_W'(total);
    t       = MUL_W'(target);
    s20     = (s << 4) + (s << 2);
    t19     = (t << 4) + (t << 1) + t;
    t21     = (t << 4) + (t << 2) + t;
    in_band = (s20 >= t19) && (s20 <= t21);
  end
endmodule

// File: rtl/hamming_eval.sv
module hamming_eval #(
  parameter int NI    = 8,
  parameter int NO    = 4,
  parameter int CNT_W = NI + 1,
  parameter int ACC_W = NI + $clog2(NO) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ACC_W-1:0]    tgt_total,
  output logic [NI-1:0]       vec,
  output logic                vec_valid,
  input  logic [NO-1:0]       ref_resp,
  input  logic [NO-1:0]       cand_resp,
  output logic                busy,
  output logic                done,
  output logic [NO*CNT_W-1:0] per_cnt,
  output logic [ACC_W-1:0]    total,
  output logic                accept,
  output logic                reject,
  output logic                equiv
);
  logic rst_meta, rst_i;
  logic rsp_vld, rsp_last;
  logic done_q, done_d;
  logic in_band;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  hev_seq #(.NI(NI)) seq_i (
    .clk       (clk),
    .rst_n     (rst_i),
    .start     (start),
    .vec       (vec),
    .vec_valid (vec_valid),
    .rsp_vld   (rsp_vld),
    .rsp_last  (rsp_last)
  );

  hev_acc #(.NO(NO), .CNT_W(CNT_W), .ACC_W(ACC_W)) acc_i (
    .clk     (clk),
    .rst_n   (rst_i),
    .clr     (start),
    .en      (rsp_vld && !start),
    .diff    (ref_resp ^ cand_resp),
    .per_cnt (per_cnt),
    .total   (total)
  );

  hev_band #(.ACC_W(ACC_W)) band_i (
    .total   (total),
    .target  (tgt_total),
    .in_band (in_band)
  );

  assign done_d = !start && rsp_vld && rsp_last;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign busy   = vec_valid || rsp_vld;
  assign done   = done_q;
  assign accept = done_q && in_band;
  assign reject = done_q && !in_band;
  assign equiv  = done_q && (total == '0);
endmodule

// File: rtl/hamming_eval_chk.sv
module hev_chk #(
  parameter int NI    = 8,
  parameter int NO    = 4,
  parameter int CNT_W = 9,
  parameter int ACC_W = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [NI-1:0]       vec,
  input logic                vec_valid,
  input logic                busy,
  input logic                done,
  input logic [NO*CNT_W-1:0] per_cnt,
  input logic [ACC_W-1:0]    total,
  input logic                accept,
  input logic                reject
);
  logic [ACC_W-1:0] psum;
  always_comb begin
    psum = '0;
    for (int i = 0; i < NO; i++) psum = psum + ACC_W'(per_cnt[i*CNT_W +: CNT_W]);
  end

  // R2
  vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !start && vec != {NI{1'b1}}) |=> (vec_valid && vec == $past(vec) + 1'b1));

  // R5
  total_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total == psum);

  // R5
  no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> total >= $past(total));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || reject) |-> (done && (accept != reject)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(per_cnt));
endmodule

bind hamming_eval hev_chk #(.NI(NI), .NO(NO), .CNT_W(CNT_W), .ACC_W(ACC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .vec       (vec),
  .vec_valid (vec_valid),
  .busy      (busy),
  .done      (done),
  .per_cnt   (per_cnt),
  .total     (total),
  .accept    (accept),
  .reject    (reject)
);

// File: tb/hamming_eval_tb_top.sv
module hamming_eval_tb_top;
  localparam int NI    = 6;
  localparam int NO    = 4;
  localparam int CNT_W = NI + 1;
  localparam int ACC_W = NI + $clog2(NO) + 1;
  localparam int NV    = 1 << NI;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [ACC_W-1:0]    tgt_total = '0;
  logic [NI-1:0]       vec;
  logic                vec_valid;
  logic [NO-1:0]       ref_resp = '0;
  logic [NO-1:0]       cand_resp = '0;
  logic                busy, done, accept, reject, equiv;
  logic [NO*CNT_W-1:0] per_cnt;
  logic [ACC_W-1:0]    total;

  int n_chk = 0;
  int n_bad = 0;
  int mode  = 0;

  always #10 clk = ~clk;

  hamming_eval #(.NI(NI), .NO(NO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_total(tgt_total),
    .vec(vec), .vec_valid(vec_valid), .ref_resp(ref_resp), .cand_resp(cand_resp),
    .busy(busy), .done(done), .per_cnt(per_cnt), .total(total),
    .accept(accept), .reject(reject), .equiv(equiv)
  );

  function automatic logic [NO-1:0] fref(input logic [NI-1:0] v);
    return {^v, v[2] | v[5], v[1] & v[4], v[0] ^ v[3]};
  endfunction

  function automatic logic [NO-1:0] flip(input logic [NI-1:0] v, input int m);
    logic [NO-1:0] f;
    f = '0;
    case (m)
      1: f[0] = v[0] & v[1];
      2: f = (v == {NI{1'b1}}) ? {NO{1'b1}} : '0;
      3: begin
        f[1] = (v[2:0] == 3'd0);
        f[2] = (v[3:1] == 3'd0);
        f[3] = (v[5:2] == 4'd0);
      end
      default: f = '0;
    endcase
    return f;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // responder: answers the vector seen at a clock edge half a cycle later
  initial begin
    logic [NI-1:0] cap;
    forever begin
      @(posedge clk);
      cap = vec;
      @(negedge clk);
      ref_resp  = fref(cap);
      cand_resp = fref(cap) ^ flip(cap, mode);
    end
  end

  task automatic pulse_start(input int m, input int tgt);
    mode      = m;
    tgt_total = ACC_W'(tgt);
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
  endtask

  task automatic full_run(input int m, input int tgt);
    int exp_c [NO];
    int exp_t;
    bit exp_acc;
    for (int i = 0; i < NO; i++) exp_c[i] = 0;
    for (int v = 0; v < NV; v++) begin
      logic [NO-1:0] f;
      f = flip(NI'(v), m);
      for (int i = 0; i < NO; i++) if (f[i]) exp_c[i]++;
    end
    exp_t = 0;
    for (int i = 0; i < NO; i++) exp_t += exp_c[i];
    exp_acc = (19 * tgt <= 20 * exp_t) && (20 * exp_t <= 21 * tgt);

    pulse_start(m, tgt);
    for (int k = 0; k < NV; k++) begin
      chk(vec_valid && vec == NI'(k), "R2 vec sweep", vec, k);
      chk(!done, "R6 no early done", done, 0);
      @(negedge clk);
    end
    chk(!vec_valid && busy, "R2 sweep end", vec_valid, 0);
    chk(!done, "R6 done not yet", done, 0);
    @(negedge clk);
    chk(done && !busy, "R6 done pulse", done, 1);
    for (int i = 0; i < NO; i++)
      chk(per_cnt[i*CNT_W +: CNT_W] == CNT_W'(exp_c[i]), "R4 R3 per-output count",
          per_cnt[i*CNT_W +: CNT_W], exp_c[i]);
    chk(total == ACC_W'(exp_t), "R5 total", total, exp_t);
    chk(accept == exp_acc, "R7 accept", accept, exp_acc);
    chk(reject == !exp_acc, "R8 reject", reject, !exp_acc);
    chk(equiv == (exp_t == 0), "R9 equiv", equiv, exp_t == 0);
    @(negedge clk);
    chk(!done && !accept && !reject && !equiv, "R8 verdict one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(total == ACC_W'(exp_t), "R10 total holds", total, exp_t);
    chk(per_cnt[0 +: CNT_W] == CNT_W'(exp_c[0]), "R10 count holds",
        per_cnt[0 +: CNT_W], exp_c[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !vec_valid && !accept && !reject && !equiv, "R1 in reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !vec_valid && total == '0 && per_cnt == '0, "R1 after reset", total, 0);

    full_run(0, 0);    // equivalent functions, zero target
    full_run(1, 16);   // total 16, target in band
    full_run(1, 15);   // 21*15 < 320: outside
    full_run(1, 17);   // 19*17 > 320: outside
    full_run(3, 21);   // total 20, 399 <= 400 lower edge inside
    full_run(3, 19);   // 399 < 400 upper edge outside
    full_run(2, 4);    // all outputs flip on last vector only

    // R11: restart mid-sweep with a different candidate
    pulse_start(3, 20);
    repeat (10) @(negedge clk);
    chk(busy && total != '0, "R11 sweep in progress", total, 1);
    full_run(1, 16);

    chk(!busy, "R11 idle at end", busy, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule